// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, called side A and side B. Each side is modelled as three signals: an input vector, an output vector and a drive-enable. Two capture registers sit between the buses. One samples side A on the rising edge of its own clock. The other samples side B on the rising edge of a separate clock. Capture goes on whatever the output controls are doing, so either register can be loaded while both buses are isolated.

The buses are enabled by an active-low global enable. While it is low, a direction input picks the single side that is driven, and the other side acts as the input. Each driven side has its own source select. The select passes either the live value from the opposite bus, through a purely combinational path, or the word held in that bus's capture register. The ports are plain level signals with no valid/ready handshake. A transfer is either live and continuous, or it happens at a capture-clock edge, so nothing on these paths can apply back-pressure.

Top module: `xcvr_reg_bus`

## Requirements
- R1: An active-low asynchronous reset clears both capture registers to zero, so stored playback returns 0 on either side after reset.
- R2: On every rising edge of `cap_a_clk`, the side-A register loads `a_in`.
- R3: On every rising edge of `cap_b_clk`, the side-B register loads `b_in`.
- R4: Capture works the same way whatever the values of `oe_n`, `dir_to_b` and the select inputs. This includes the isolated state.
- R5: While `oe_n` is 1, `a_drive` and `b_drive` are both 0. An output that is not driven reads as zero.
- R6: While `oe_n` is 0, `dir_to_b`=0 drives side A (`a_drive`=1, `b_drive`=0), and `dir_to_b`=1 drives side B (`b_drive`=1, `a_drive`=0).
- R7: When side B is driven, `b_out` equals the live `a_in` if `b_src_held`=0, and the side-A register if `b_src_held`=1.
- R8: When side A is driven, `a_out` equals the live `b_in` if `a_src_held`=0, and the side-B register if `a_src_held`=1.
- R9: `a_drive` and `b_drive` are never 1 at the same time.
- R10: A register with no rising edge on its capture clock keeps its contents, whatever its bus input does.
- R11: A change on the live input shows on the driven output in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| cap_a_clk | input | 1 | Rising edge captures side A |
| cap_b_clk | input | 1 | Rising edge captures side B |
| oe_n | input | 1 | Active-low global output enable |
| dir_to_b | input | 1 | 0: drive side A, 1: drive side B |
| b_src_held | input | 1 | Source for side B: 0 live A, 1 stored A |
| a_src_held | input | 1 | Source for side A: 0 live B, 1 stored B |
| a_in | input | W | Side A bus input |
| a_out | output | W | Side A bus output value |
| a_drive | output | 1 | Side A drive-enable |
| b_in | input | W | Side B bus input |
| b_out | output | W | Side B bus output value |
| b_drive | output | 1 | Side B drive-enable |

## Verification
The bench loads registers while the buses are isolated. A design that gated capture with the output enable would then play back stale data. It changes bus inputs between capture edges. This catches two faults: a design whose registers follow the bus transparently, and a design whose live path waits for a clock and so shows the old value. It checks every combination of direction and enable against both drive-enables, which exposes swapped direction decoding or two sides driving at once. It also pulses reset after loading, to catch registers that do not clear.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int DATA_W = 8;
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir_to_b,
  output logic drv_a,
  output logic drv_b
);
  side_e target;
  assign target = side_e'(dir_to_b);
  always_comb begin
    drv_a = 1'b0;
    drv_b = 1'b0;
    if (!oe_n) begin
      unique case (target)
        SIDE_A: drv_a = 1'b1;
        SIDE_B: drv_b = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_side_mux.sv
module xcvr_side_mux
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         pick_held,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] y
);
  src_e src;
  assign src = src_e'(pick_held);
  always_comb begin
    y = '0;
    if (en) begin
      unique case (src)
        SRC_LIVE: y = live;
        SRC_HELD: y = held;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_reg_bus.sv
module xcvr_reg_bus
  import xcvr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         rst_n,
  input  logic         cap_a_clk,
  input  logic         cap_b_clk,
  input  logic         oe_n,
  input  logic         dir_to_b,
  input  logic         b_src_held,
  input  logic         a_src_held,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive
);
  logic [W-1:0] held_a;
  logic [W-1:0] held_b;

  xcvr_cap_reg #(.W(W)) u_reg_a (.clk(cap_a_clk), .rst_n(rst_n), .d(a_in), .q(held_a));
  xcvr_cap_reg #(.W(W)) u_reg_b (.clk(cap_b_clk), .rst_n(rst_n), .d(b_in), .q(held_b));

  xcvr_drive_ctl u_ctl (.oe_n(oe_n), .dir_to_b(dir_to_b), .drv_a(a_drive), .drv_b(b_drive));

  xcvr_side_mux #(.W(W)) u_mux_b (
    .en(b_drive), .pick_held(b_src_held), .live(a_in), .held(held_a), .y(b_out));
  xcvr_side_mux #(.W(W)) u_mux_a (
    .en(a_drive), .pick_held(a_src_held), .live(b_in), .held(held_b), .y(a_out));
endmodule

// File: rtl/xcvr_reg_bus_chk.sv
module xcvr_reg_bus_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         cap_a_clk,
  input logic         cap_b_clk,
  input logic         oe_n,
  input logic         a_src_held,
  input logic         b_src_held,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_drive,
  input logic         b_drive,
  input logic [W-1:0] held_a,
  input logic [W-1:0] held_b
);
  logic [W-1:0] shadow_a;
  logic [W-1:0] shadow_b;

  always_ff @(posedge cap_a_clk or negedge rst_n)
    if (!rst_n) shadow_a <= '0; else shadow_a <= a_in;
  always_ff @(posedge cap_b_clk or negedge rst_n)
    if (!rst_n) shadow_b <= '0; else shadow_b <= b_in;

  AST_A_CAPTURE: assert property (@(posedge cap_b_clk) disable iff (!rst_n)
    held_a == shadow_a); // R2
  AST_B_CAPTURE: assert property (@(posedge cap_a_clk) disable iff (!rst_n)
    held_b == shadow_b); // R3
  AST_ONE_DRIVER: assert property (@(posedge cap_a_clk) disable iff (!rst_n)
    !(a_drive && b_drive)); // R9
  AST_ISOLATE: assert property (@(posedge cap_b_clk) disable iff (!rst_n)
    oe_n |-> (!a_drive && !b_drive)); // R5
  AST_B_LIVE: assert property (@(posedge cap_a_clk) disable iff (!rst_n)
    (b_drive && !b_src_held) |-> b_out == a_in); // R7
  AST_A_HELD: assert property (@(posedge cap_a_clk) disable iff (!rst_n)
    (a_drive && a_src_held) |-> a_out == held_b); // R8
endmodule

bind xcvr_reg_bus xcvr_reg_bus_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk), .oe_n(oe_n),
  .a_src_held(a_src_held), .b_src_held(b_src_held), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_drive(a_drive), .b_drive(b_drive),
  .held_a(held_a), .held_b(held_b));

// File: tb/tb_xcvr_reg_bus.sv
module tb_xcvr_reg_bus;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n, cap_a_clk, cap_b_clk, oe_n, dir_to_b, b_src_held, a_src_held;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_drive, b_drive;
  logic [W-1:0] m_a, m_b;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  xcvr_reg_bus #(.W(W)) dut (
    .rst_n(rst_n), .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk), .oe_n(oe_n),
    .dir_to_b(dir_to_b), .b_src_held(b_src_held), .a_src_held(a_src_held),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic exp_adrv(); return !oe_n && !dir_to_b; endfunction
  function automatic logic exp_bdrv(); return !oe_n && dir_to_b; endfunction
  function automatic logic [W-1:0] exp_aout();
    return exp_adrv() ? (a_src_held ? m_b : b_in) : '0;
  endfunction
  function automatic logic [W-1:0] exp_bout();
    return exp_bdrv() ? (b_src_held ? m_a : a_in) : '0;
  endfunction

  task automatic cmp(string what, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    #1;
    cmp("a_drive", "R6", W'(a_drive), W'(exp_adrv()));
    cmp("b_drive", "R6", W'(b_drive), W'(exp_bdrv()));
    cmp("a_out", "R8", a_out, exp_aout());
    cmp("b_out", "R7", b_out, exp_bout());
    cmp("one driver", "R9", W'(a_drive && b_drive), '0);
  endtask

  task automatic pulse_a();
    #1 cap_a_clk = 1'b1; m_a = a_in;
    #1 cap_a_clk = 1'b0;
  endtask
  task automatic pulse_b();
    #1 cap_b_clk = 1'b1; m_b = b_in;
    #1 cap_b_clk = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cap_a_clk = 1'b0; cap_b_clk = 1'b0; oe_n = 1'b1; dir_to_b = 1'b0;
    b_src_held = 1'b0; a_src_held = 1'b0; a_in = '0; b_in = '0; m_a = '0; m_b = '0;
    #1;
    cmp("a_drive isolated", "R5", W'(a_drive), '0);
    cmp("b_drive isolated", "R5", W'(b_drive), '0);
    #10 rst_n = 1'b1;
    // R1: stored playback is zero after reset
    oe_n = 1'b0; dir_to_b = 1'b1; b_src_held = 1'b1; a_in = 8'hA5; #1;
    cmp("b_out stored after reset", "R1", b_out, 8'h00);
    dir_to_b = 1'b0; a_src_held = 1'b1; b_in = 8'h3C; #1;
    cmp("a_out stored after reset", "R1", a_out, 8'h00);
    // R4: capture while isolated
    oe_n = 1'b1; a_in = 8'h5A; b_in = 8'hC3; pulse_a(); pulse_b();
    check_all();
    cmp("a_out isolated", "R5", a_out, 8'h00);
    a_in = 8'h11; b_in = 8'h22; // R10: no edge, registers hold
    oe_n = 1'b0; dir_to_b = 1'b1; b_src_held = 1'b1; #1;
    cmp("b_out held A", "R4", b_out, 8'h5A);
    cmp("b_out held A no edge", "R10", b_out, 8'h5A);
    dir_to_b = 1'b0; a_src_held = 1'b1; #1;
    cmp("a_out held B", "R4", a_out, 8'hC3);
    // R2 / R3 while driving
    pulse_b(); #1;
    cmp("a_out after B capture", "R3", a_out, 8'h22);
    dir_to_b = 1'b1; pulse_a(); #1;
    cmp("b_out after A capture", "R2", b_out, 8'h11);
    // R11: live path follows without any clock
    b_src_held = 1'b0; a_in = 8'hE7; #1;
    cmp("b_out live", "R11", b_out, 8'hE7);
    dir_to_b = 1'b0; a_src_held = 1'b0; b_in = 8'h99; #1;
    cmp("a_out live", "R11", a_out, 8'h99);
    // R1: asynchronous reset after loading
    a_src_held = 1'b1; rst_n = 1'b0; m_a = '0; m_b = '0; #1;
    cmp("a_out after async reset", "R1", a_out, 8'h00);
    #2 rst_n = 1'b1;
    check_all();
    // random mix
    for (int i = 0; i < 400; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      oe_n = 1'($urandom); dir_to_b = 1'($urandom);
      b_src_held = 1'($urandom); a_src_held = 1'($urandom);
      check_all();
      if ($urandom % 2 == 0) pulse_a();
      if ($urandom % 2 == 0) pulse_b();
      check_all();
      a_in = W'($urandom); b_in = W'($urandom);
      check_all();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule